// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Hazard Unit

This block sits beside the decode and execute stages of a five-stage, in-order RV32 pipeline. It picks where each source operand comes from. The choices are the result held in the EX/MEM stage, the result held in the MEM/WB stage, or the value read from the register file. It makes this choice twice: once for the operands being captured at decode, and once for the operands leaving the ID/EX register into execute. The block owns the ID/EX operand registers and the ID/EX control bits it needs, which are valid, register-write, load flag and register addresses.

The block also spots the case where a load in ID/EX produces a register that the instruction now in decode reads. When that happens it asserts a stall for the fetch and decode stages and turns the next ID/EX entry into a bubble. The bubble carries neither a valid bit nor a write-enable, so it can never act as a forwarding source further down the pipe. The block also produces the write-enable for register writeback. The ALU and the register file storage are outside the block.

Top module: `fwd_hazard_unit`

## Requirements
- R1: The execute operand for a source register is the EX/MEM result when EX/MEM is valid, has its write flag set, its destination equals that source, and the source is not register 0. A stage that is invalid or not writing is never used as a source.
- R2: EX/MEM wins over MEM/WB when both match. The MEM/WB result (under the same valid, write and nonzero-match rules) is used only when EX/MEM does not match. With no match, the execute operand is the value held in the ID/EX operand register.
- R3: The decode operands apply the same two-level choice over the register-file read data. On a clock edge without a hazard, ID/EX takes the decode operands, register addresses and destination. It also takes valid = decode valid, write = decode valid AND decode write flag, and load = decode valid AND decode load flag.
- R4: A hazard is flagged when ID/EX holds a valid load, decode is valid, and the load's destination equals decode rs1, which is not register 0.
- R5: A hazard on rs2 (destination equals decode rs2, rs2 not register 0) is flagged only when the decoded instruction is R-type, a store or a branch. For any other type, an rs2-only match raises no stall.
- R6: During a hazard cycle, both stall and bubble are high in that same cycle. At the next edge ID/EX valid, write and load flags are cleared, while its operands and addresses hold. The stall therefore lasts exactly one cycle.
- R7: Writeback enable is high only when MEM/WB is valid, has its write flag set, and its destination is not register 0.
- R8: After reset the ID/EX valid, write and load flags are 0, the destination is 0, and stall and bubble are low.
- R9: A source address of register 0 always takes the register-file value (decode) or the held ID/EX value (execute), even when a stage writing register 0 is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | IF/ID holds an instruction |
| decRs1 | input | AW | Decoded first source |
| decRs2 | input | AW | Decoded second source |
| decRd | input | AW | Decoded destination |
| decRegWrite | input | 1 | Decoded instruction writes a register |
| decIsLoad | input | 1 | Decoded instruction is a load |
| decIsRType | input | 1 | Decoded instruction is register-register |
| decIsStore | input | 1 | Decoded instruction is a store |
| decIsBranch | input | 1 | Decoded instruction is a conditional branch |
| rfRs1Data | input | XW | Register-file read for rs1 |
| rfRs2Data | input | XW | Register-file read for rs2 |
| exMemValid | input | 1 | EX/MEM holds an instruction |
| exMemRegWrite | input | 1 | EX/MEM writes a register |
| exMemRd | input | AW | EX/MEM destination |
| exMemResult | input | XW | EX/MEM result |
| memWbValid | input | 1 | MEM/WB holds an instruction |
| memWbRegWrite | input | 1 | MEM/WB writes a register |
| memWbRd | input | AW | MEM/WB destination |
| memWbResult | input | XW | MEM/WB result |
| decOpA | output | XW | Forwarded first decode operand |
| decOpB | output | XW | Forwarded second decode operand |
| exOpA | output | XW | Forwarded first execute operand |
| exOpB | output | XW | Forwarded second execute operand |
| stall | output | 1 | Hold fetch and decode |
| bubble | output | 1 | Insert a bubble into ID/EX |
| idExValid | output | 1 | ID/EX valid bit |
| idExRegWrite | output | 1 | ID/EX write flag |
| idExIsLoad | output | 1 | ID/EX load flag |
| idExRd | output | AW | ID/EX destination |
| wbEnable | output | 1 | Register-file write enable |

## Verification
If the ID/EX control bits go wrong, for example a bubble that keeps its write flag or a missed capture, the fault shows at the ID/EX flag ports one edge after the hazard cycle. It also shows in that same cycle on stall, because stall depends on the held load flag. If the held operands go wrong, the execute operands differ from the bench model on the first cycle where no later stage matches the source. Mistakes in source choice, priority or the register-0 rule show in the same cycle on the four operand outputs, because those paths are purely combinational. The sweep keeps register addresses in a small range so that matches, double matches and register-0 cases occur often.

// File: rtl/fwd_hazard_pkg.sv
`timescale 1ns/1ps
package fwd_hazard_pkg;

  // Where an operand is taken from; EX/MEM has the highest rank.
  typedef enum logic [1:0] {
    SRC_HELD  = 2'd0,  // register file (decode) or held ID/EX value (execute)
    SRC_MEMWB = 2'd1,
    SRC_EXMEM = 2'd2
  } srcSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    srcSel_e exSelA;
    srcSel_e exSelB;
    srcSel_e decSelA;
    srcSel_e decSelB;
    logic    capture;  // load decode operands into ID/EX
  } fwdStrobes_t;

endpackage

// File: rtl/fwd_hazard_ctrl.sv
`timescale 1ns/1ps
module fwd_hazard_ctrl
  import fwd_hazard_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          decValid,
  input  logic [AW-1:0] decRs1,
  input  logic [AW-1:0] decRs2,
  input  logic [AW-1:0] decRd,
  input  logic          decRegWrite,
  input  logic          decIsLoad,
  input  logic          decIsRType,
  input  logic          decIsStore,
  input  logic          decIsBranch,
  input  logic          exMemValid,
  input  logic          exMemRegWrite,
  input  logic [AW-1:0] exMemRd,
  input  logic          memWbValid,
  input  logic          memWbRegWrite,
  input  logic [AW-1:0] memWbRd,
  output fwdStrobes_t   strobes,
  output logic          stall,
  output logic          bubble,
  output logic          idExValid,
  output logic          idExRegWrite,
  output logic          idExIsLoad,
  output logic [AW-1:0] idExRd,
  output logic          wbEnable
);

  localparam logic [AW-1:0] ZeroReg = '0;

  logic [AW-1:0] idExRs1;
  logic [AW-1:0] idExRs2;
  logic          hazard;
  logic          usesRs2;
  logic          clashRs1;
  logic          clashRs2;

  // Two-level source choice for one register address.
  function automatic srcSel_e pickSource(input logic [AW-1:0] src,
                                         input logic exV, input logic exW,
                                         input logic [AW-1:0] exRd,
                                         input logic mwV, input logic mwW,
                                         input logic [AW-1:0] mwRd);
    if (src == ZeroReg)                   return SRC_HELD;
    else if (exV && exW && exRd == src)   return SRC_EXMEM;
    else if (mwV && mwW && mwRd == src)   return SRC_MEMWB;
    else                                  return SRC_HELD;
  endfunction

  always_comb begin
    strobes.exSelA  = pickSource(idExRs1, exMemValid, exMemRegWrite, exMemRd,
                                 memWbValid, memWbRegWrite, memWbRd);
    strobes.exSelB  = pickSource(idExRs2, exMemValid, exMemRegWrite, exMemRd,
                                 memWbValid, memWbRegWrite, memWbRd);
    strobes.decSelA = pickSource(decRs1, exMemValid, exMemRegWrite, exMemRd,
                                 memWbValid, memWbRegWrite, memWbRd);
    strobes.decSelB = pickSource(decRs2, exMemValid, exMemRegWrite, exMemRd,
                                 memWbValid, memWbRegWrite, memWbRd);
    strobes.capture = !hazard;
  end

  // Load-use detection against the instruction in decode.
  assign usesRs2  = decIsRType || decIsStore || decIsBranch;
  assign clashRs1 = (decRs1 != ZeroReg) && (idExRd == decRs1);
  assign clashRs2 = (decRs2 != ZeroReg) && (idExRd == decRs2) && usesRs2;
  assign hazard   = idExValid && idExIsLoad && decValid && (clashRs1 || clashRs2);
  assign stall    = hazard;
  assign bubble   = hazard;

  assign wbEnable = memWbValid && memWbRegWrite && (memWbRd != ZeroReg);

  // ID/EX control register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idExValid    <= 1'b0;
      idExRegWrite <= 1'b0;
      idExIsLoad   <= 1'b0;
      idExRd       <= '0;
      idExRs1      <= '0;
      idExRs2      <= '0;
    end else if (hazard) begin
      idExValid    <= 1'b0;
      idExRegWrite <= 1'b0;
      idExIsLoad   <= 1'b0;
    end else begin
      idExValid    <= decValid;
      idExRegWrite <= decValid && decRegWrite;
      idExIsLoad   <= decValid && decIsLoad;
      idExRd       <= decRd;
      idExRs1      <= decRs1;
      idExRs2      <= decRs2;
    end
  end

  assert_bubble_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    bubble |=> (!idExValid && !idExRegWrite && !idExIsLoad));

  assert_single_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  assert_stall_needs_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (idExValid && idExIsLoad && decValid));

  assert_capture_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!bubble && decValid) |=> idExValid);

  assert_wb_not_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    wbEnable |-> (memWbRd != ZeroReg && memWbValid));

endmodule

// File: rtl/fwd_operand_path.sv
`timescale 1ns/1ps
module fwd_operand_path
  import fwd_hazard_pkg::*;
#(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  fwdStrobes_t   strobes,
  input  logic [XW-1:0] rfRs1Data,
  input  logic [XW-1:0] rfRs2Data,
  input  logic [XW-1:0] exMemResult,
  input  logic [XW-1:0] memWbResult,
  output logic [XW-1:0] decOpA,
  output logic [XW-1:0] decOpB,
  output logic [XW-1:0] exOpA,
  output logic [XW-1:0] exOpB
);

  localparam int NumOps = 2;

  logic [XW-1:0] rfData [NumOps];
  logic [XW-1:0] decOp  [NumOps];
  logic [XW-1:0] heldOp [NumOps];
  logic [XW-1:0] exOp   [NumOps];
  srcSel_e       decSel [NumOps];
  srcSel_e       exSel  [NumOps];

  function automatic logic [XW-1:0] muxSource(input srcSel_e sel,
                                              input logic [XW-1:0] fallback,
                                              input logic [XW-1:0] exRes,
                                              input logic [XW-1:0] mwRes);
    case (sel)
      SRC_EXMEM: return exRes;
      SRC_MEMWB: return mwRes;
      default:   return fallback;
    endcase
  endfunction

  assign rfData[0] = rfRs1Data;
  assign rfData[1] = rfRs2Data;
  assign decSel[0] = strobes.decSelA;
  assign decSel[1] = strobes.decSelB;
  assign exSel[0]  = strobes.exSelA;
  assign exSel[1]  = strobes.exSelB;

  for (genvar g = 0; g < NumOps; g++) begin : gOperand
    assign decOp[g] = muxSource(decSel[g], rfData[g], exMemResult, memWbResult);
    assign exOp[g]  = muxSource(exSel[g], heldOp[g], exMemResult, memWbResult);

    always_ff @(posedge clk) begin
      if (!rstN)                heldOp[g] <= '0;
      else if (strobes.capture) heldOp[g] <= decOp[g];
    end
  end

  assign decOpA = decOp[0];
  assign decOpB = decOp[1];
  assign exOpA  = exOp[0];
  assign exOpB  = exOp[1];

  assert_held_matches_decode_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (strobes.exSelA != SRC_HELD || exOpA == $past(decOpA)));

  assert_held_stable_on_bubble_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> (strobes.exSelB != SRC_HELD || exOpB == $past(heldOp[1])));

endmodule

// File: rtl/fwd_hazard_unit.sv
`timescale 1ns/1ps
module fwd_hazard_unit
  import fwd_hazard_pkg::*;
#(
  parameter int XW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          decValid,
  input  logic [AW-1:0] decRs1,
  input  logic [AW-1:0] decRs2,
  input  logic [AW-1:0] decRd,
  input  logic          decRegWrite,
  input  logic          decIsLoad,
  input  logic          decIsRType,
  input  logic          decIsStore,
  input  logic          decIsBranch,
  input  logic [XW-1:0] rfRs1Data,
  input  logic [XW-1:0] rfRs2Data,
  input  logic          exMemValid,
  input  logic          exMemRegWrite,
  input  logic [AW-1:0] exMemRd,
  input  logic [XW-1:0] exMemResult,
  input  logic          memWbValid,
  input  logic          memWbRegWrite,
  input  logic [AW-1:0] memWbRd,
  input  logic [XW-1:0] memWbResult,
  output logic [XW-1:0] decOpA,
  output logic [XW-1:0] decOpB,
  output logic [XW-1:0] exOpA,
  output logic [XW-1:0] exOpB,
  output logic          stall,
  output logic          bubble,
  output logic          idExValid,
  output logic          idExRegWrite,
  output logic          idExIsLoad,
  output logic [AW-1:0] idExRd,
  output logic          wbEnable
);

  fwdStrobes_t strobes;

  fwd_hazard_ctrl #(.AW(AW)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .decValid(decValid), .decRs1(decRs1), .decRs2(decRs2), .decRd(decRd),
    .decRegWrite(decRegWrite), .decIsLoad(decIsLoad), .decIsRType(decIsRType),
    .decIsStore(decIsStore), .decIsBranch(decIsBranch),
    .exMemValid(exMemValid), .exMemRegWrite(exMemRegWrite), .exMemRd(exMemRd),
    .memWbValid(memWbValid), .memWbRegWrite(memWbRegWrite), .memWbRd(memWbRd),
    .strobes(strobes), .stall(stall), .bubble(bubble),
    .idExValid(idExValid), .idExRegWrite(idExRegWrite), .idExIsLoad(idExIsLoad),
    .idExRd(idExRd), .wbEnable(wbEnable)
  );

  fwd_operand_path #(.XW(XW)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rfRs1Data(rfRs1Data), .rfRs2Data(rfRs2Data),
    .exMemResult(exMemResult), .memWbResult(memWbResult),
    .decOpA(decOpA), .decOpB(decOpB), .exOpA(exOpA), .exOpB(exOpB)
  );

endmodule

// File: tb/test_fwd_hazard_unit.sv
`timescale 1ns/1ps
module test_fwd_hazard_unit;

  localparam int XW = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          decValid = 0, decRegWrite = 0, decIsLoad = 0;
  logic          decIsRType = 0, decIsStore = 0, decIsBranch = 0;
  logic [AW-1:0] decRs1 = 0, decRs2 = 0, decRd = 0;
  logic [XW-1:0] rfRs1Data = 0, rfRs2Data = 0, exMemResult = 0, memWbResult = 0;
  logic          exMemValid = 0, exMemRegWrite = 0, memWbValid = 0, memWbRegWrite = 0;
  logic [AW-1:0] exMemRd = 0, memWbRd = 0;
  logic [XW-1:0] decOpA, decOpB, exOpA, exOpB;
  logic          stall, bubble, idExValid, idExRegWrite, idExIsLoad, wbEnable;
  logic [AW-1:0] idExRd;

  fwd_hazard_unit #(.XW(XW), .AW(AW)) i_fwd_hazard_unit (.*);

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  // Model of ID/EX
  logic          mValid = 0, mRw = 0, mLoad = 0;
  logic [AW-1:0] mRd = 0, mRs1 = 0, mRs2 = 0;
  logic [XW-1:0] mOpA = 0, mOpB = 0;

  task automatic check(input string tag, input logic [XW-1:0] got, input logic [XW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic [XW-1:0] expFwd(input logic [AW-1:0] src, input logic [XW-1:0] fallback);
    if (src == 0) return fallback;
    if (exMemValid && exMemRegWrite && exMemRd == src) return exMemResult;
    if (memWbValid && memWbRegWrite && memWbRd == src) return memWbResult;
    return fallback;
  endfunction

  function automatic logic expHazard();
    logic usesB = decIsRType || decIsStore || decIsBranch;
    return mValid && mLoad && decValid &&
           ((decRs1 != 0 && mRd == decRs1) || (decRs2 != 0 && mRd == decRs2 && usesB));
  endfunction

  // Inputs are stable here (driven on the previous falling edge).
  task automatic runCycle();
    logic haz;
    logic [XW-1:0] eA, eB;
    #1;
    haz = expHazard();
    eA = expFwd(decRs1, rfRs1Data);
    eB = expFwd(decRs2, rfRs2Data);
    check("R4 R5 stall", {31'b0, stall}, {31'b0, haz});
    check("R6 bubble", {31'b0, bubble}, {31'b0, haz});
    check("R3 R9 decOpA", decOpA, eA);
    check("R3 R9 decOpB", decOpB, eB);
    check("R1 R2 R9 exOpA", exOpA, expFwd(mRs1, mOpA));
    check("R1 R2 R9 exOpB", exOpB, expFwd(mRs2, mOpB));
    check("R7 wbEnable", {31'b0, wbEnable},
          {31'b0, memWbValid && memWbRegWrite && memWbRd != 0});
    @(posedge clk);
    if (haz) begin
      mValid = 0; mRw = 0; mLoad = 0;
    end else begin
      mValid = decValid; mRw = decValid && decRegWrite; mLoad = decValid && decIsLoad;
      mRd = decRd; mRs1 = decRs1; mRs2 = decRs2; mOpA = eA; mOpB = eB;
    end
    #1;
    check("R3 R6 idExValid", {31'b0, idExValid}, {31'b0, mValid});
    check("R3 R6 idExRegWrite", {31'b0, idExRegWrite}, {31'b0, mRw});
    check("R3 R6 idExIsLoad", {31'b0, idExIsLoad}, {31'b0, mLoad});
    check("R3 idExRd", {27'b0, idExRd}, {27'b0, mRd});
    @(negedge clk);
  endtask

  task automatic randomInputs();
    seed = nextRand(seed); decRs1 = AW'(seed[1:0]); decRs2 = AW'(seed[3:2]); decRd = AW'(seed[5:4]);
    decValid = seed[8] | seed[9]; decRegWrite = seed[10]; decIsLoad = seed[11];
    decIsRType = seed[12] & seed[13]; decIsStore = seed[14] & seed[15]; decIsBranch = seed[16] & seed[17];
    exMemRd = AW'(seed[19:18]); memWbRd = AW'(seed[21:20]);
    exMemValid = seed[22] | seed[23]; exMemRegWrite = seed[24] | seed[25];
    memWbValid = seed[26] | seed[27]; memWbRegWrite = seed[28] | seed[29];
    seed = nextRand(seed); rfRs1Data = seed;
    seed = nextRand(seed); rfRs2Data = seed;
    seed = nextRand(seed); exMemResult = seed;
    seed = nextRand(seed); memWbResult = seed;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    check("R8 idExValid", {31'b0, idExValid}, 32'd0);
    check("R8 idExRegWrite", {31'b0, idExRegWrite}, 32'd0);
    check("R8 idExIsLoad", {31'b0, idExIsLoad}, 32'd0);
    check("R8 idExRd", {27'b0, idExRd}, 32'd0);
    check("R8 stall", {31'b0, stall}, 32'd0);
    @(negedge clk);
    rstN = 1;

    // R5 directed: load x3 then an I-type reading x3 only as rs2 -> no stall
    decValid = 1; decIsLoad = 1; decRegWrite = 1; decRd = 3; decRs1 = 1; decRs2 = 0;
    runCycle();
    decIsLoad = 0; decRd = 4; decRs1 = 2; decRs2 = 3;
    decIsRType = 0; decIsStore = 0; decIsBranch = 0;
    runCycle();
    // R4/R6 directed: load x3 then R-type reading x3 as rs1 -> one-cycle stall
    decIsLoad = 1; decRd = 3; decRs1 = 1; decRs2 = 0;
    runCycle();
    decIsLoad = 0; decIsRType = 1; decRd = 5; decRs1 = 3; decRs2 = 2;
    runCycle();
    runCycle();
    // R9/R2 directed: stages write x0 and both match x2
    decIsRType = 0; decRs1 = 0; decRs2 = 2;
    exMemValid = 1; exMemRegWrite = 1; exMemRd = 2; exMemResult = 32'hAAAA_0001;
    memWbValid = 1; memWbRegWrite = 1; memWbRd = 2; memWbResult = 32'hBBBB_0002;
    rfRs1Data = 32'h1111_1111; rfRs2Data = 32'h2222_2222;
    runCycle();
    exMemRd = 0; memWbRd = 0;
    runCycle();

    for (int i = 0; i < 4000; i++) begin
      randomInputs();
      runCycle();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule